// File: doc/BRIEF.md
# Mode-Programmable Clock Divider Banks

This block is the digital output stage of a PLL-based clock driver. It takes a fast oscillator clock and a reference clock and produces one feedback clock and three banks of bank clocks (4, 8 and 5 wide by default). A 4-bit mode word selects, from one fixed table, an independent divide ratio of 1, 2, 3 or 4 for the feedback output and for each bank. Every output runs at about 50% duty. Odd ratios reach this by combining a rising-edge counter with a copy retimed on the falling edge.

The clock source is the oscillator when `pll_en_i` is high. When `pll_en_i` is low, the reference clock replaces it for test use. All dividers leave reset on the same source edge. A new mode is applied only at sync points, which come every `SYNC_LEN` source cycles and sit where every counter is at zero. Each bank has an active-low enable that parks its data low and drops the pad drive enable for that bank. The feedback output has no enable. The lock output qualifies an external lock-detect input.

Top module: `clkdiv_banks`

## Requirements
- R1: The feedback ratio for modes 0 to 15 is 1,1,1,1,1,3,3,3,2,2,2,2,2,4,4,4 source cycles.
- R2: All bits of bank A run at the source rate (ratio 1) in every mode, and all bits of a bank always carry the same value.
- R3: The bank B ratio for modes 0 to 15 is 1,1,1,2,3,1,3,1,1,2,2,2,4,2,2,2.
- R4: The bank C ratio for modes 0 to 15 is 1,2,1,2,1,3,1,1,1,1,2,4,2,1,2,4.
- R5: An output of ratio N is high for N source half-periods and low for the next N, so ratio 3 gives a 1.5-cycle high time.
- R6: Every output begins its high phase on source rising edge 0 (the first one after reset release) and again on every sync edge.
- R7: `mode_i` is sampled on edge 0 and on each edge k*SYNC_LEN (SYNC_LEN = 12), and only on those edges; values presented at other times have no effect until the next such edge.
- R8: When `oe_ni[k]` is 1 (bit 0 = bank A, 1 = B, 2 = C), bank k data is 0 and `drv_en_o[k]` is 0. When it is 0, bank k is driven and `drv_en_o[k]` is 1. `fb_o` is never gated.
- R9: With `pll_en_i` low, the reference clock is the source for every divider, and all ratios and timing apply to reference edges.
- R10: While `rst_ni` is low, every output (`fb_o`, all bank bits and `lock_o`) is 0.
- R11: `lock_o` equals `lock_det_i` delayed by two source rising edges, and it is forced to 0 whenever `pll_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock |
| ref_clk_i | input | 1 | Reference clock, used as the source in bypass |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_en_i | input | 1 | 1 selects the oscillator, 0 selects the reference |
| mode_i | input | 4 | Mode word, 0 to 15 |
| oe_ni | input | 3 | Active-low bank enables (bit 0 A, bit 1 B, bit 2 C) |
| lock_det_i | input | 1 | Raw lock indication from the loop |
| fb_o | output | 1 | Feedback clock, always driven |
| bank_a_o | output | BANK_A_W | Bank A clocks |
| bank_b_o | output | BANK_B_W | Bank B clocks |
| bank_c_o | output | BANK_C_W | Bank C clocks |
| drv_en_o | output | 3 | Pad drive enables, one per bank |
| lock_o | output | 1 | Qualified lock flag |

## Verification
The bench builds the block with its default values: bank widths 4, 8 and 5, a maximum ratio of 4 and a sync period of 12. The short sync period puts a mode boundary every 12 source cycles. Mode words can therefore be changed mid-period and between boundaries, and every ratio-to-ratio switch, including odd to even, is reached within a few thousand cycles. The bench samples each half-period of the source clock, so the 1.5-cycle high time of ratio 3 and the edge-0 alignment are observed directly, both from the oscillator and, in bypass, from the reference.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef logic [2:0] ratio_t;

  typedef struct packed {
    ratio_t fb;
    ratio_t a;
    ratio_t b;
    ratio_t c;
  } ratio_set_t;

  function automatic ratio_set_t decode_mode(input logic [3:0] mode);
    ratio_set_t rs;
    rs.a = 3'd1;
    unique case (mode)
      4'd0:  begin rs.fb = 3'd1; rs.b = 3'd1; rs.c = 3'd1; end
      4'd1:  begin rs.fb = 3'd1; rs.b = 3'd1; rs.c = 3'd2; end
      4'd2:  begin rs.fb = 3'd1; rs.b = 3'd1; rs.c = 3'd1; end
      4'd3:  begin rs.fb = 3'd1; rs.b = 3'd2; rs.c = 3'd2; end
      4'd4:  begin rs.fb = 3'd1; rs.b = 3'd3; rs.c = 3'd1; end
      4'd5:  begin rs.fb = 3'd3; rs.b = 3'd1; rs.c = 3'd3; end
      4'd6:  begin rs.fb = 3'd3; rs.b = 3'd3; rs.c = 3'd1; end
      4'd7:  begin rs.fb = 3'd3; rs.b = 3'd1; rs.c = 3'd1; end
      4'd8:  begin rs.fb = 3'd2; rs.b = 3'd1; rs.c = 3'd1; end
      4'd9:  begin rs.fb = 3'd2; rs.b = 3'd2; rs.c = 3'd1; end
      4'd10: begin rs.fb = 3'd2; rs.b = 3'd2; rs.c = 3'd2; end
      4'd11: begin rs.fb = 3'd2; rs.b = 3'd2; rs.c = 3'd4; end
      4'd12: begin rs.fb = 3'd2; rs.b = 3'd4; rs.c = 3'd2; end
      4'd13: begin rs.fb = 3'd4; rs.b = 3'd2; rs.c = 3'd1; end
      4'd14: begin rs.fb = 3'd4; rs.b = 3'd2; rs.c = 3'd2; end
      default: begin rs.fb = 3'd4; rs.b = 3'd2; rs.c = 3'd4; end
    endcase
    return rs;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_LEN = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  output logic       run_o,
  output logic       load_o,
  output logic [3:0] mode_q_o,
  output ratio_set_t ratio_nxt_o
);

  localparam int MW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;

  logic          run_q;
  logic [MW-1:0] master_q;
  logic [3:0]    mode_q;
  logic          load;

  // load on first edge after reset, then once per sync period
  assign load = !run_q || (master_q == MW'(SYNC_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      master_q <= '0;
      mode_q   <= '0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        master_q <= '0;
        mode_q   <= mode_i;
      end else begin
        master_q <= master_q + 1'b1;
      end
    end
  end

  assign run_o       = run_q;
  assign load_o      = load;
  assign mode_q_o    = mode_q;
  assign ratio_nxt_o = decode_mode(mode_i);

endmodule

// File: rtl/clkdiv_divider.sv
module clkdiv_divider
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   load_i,
  input  ratio_t ratio_i,
  output logic   lead_o,
  output logic   div_o
);

  ratio_t           rat_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             hi_q, hi_nxt, hi_n;

  always_comb begin
    if (load_i) begin
      cnt_nxt = '0;
      hi_nxt  = (ratio_i >= 3'd2);
    end else begin
      if (int'(cnt_q) + 1 >= int'(rat_q)) cnt_nxt = '0;
      else                                cnt_nxt = cnt_q + 1'b1;
      hi_nxt = (int'(cnt_nxt) < int'(rat_q >> 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rat_q <= 3'd1;
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      if (load_i) rat_q <= ratio_i;
      cnt_q <= cnt_nxt;
      hi_q  <= hi_nxt;
    end
  end

  // falling-edge copy stretches odd ratios by half a cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_n <= 1'b0;
    else         hi_n <= hi_q & rat_q[0];
  end

  assign lead_o = hi_q;
  assign div_o  = (rat_q == 3'd1) ? (clk_i & run_i) : (hi_q | hi_n);

endmodule

// File: rtl/clkdiv_lock_sync.sv
module clkdiv_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic qual_i,
  output logic lock_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], det_i};
  end

  assign lock_o = qual_i & sh_q[STAGES-1];

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int BANK_A_W = 4,
  parameter int BANK_B_W = 8,
  parameter int BANK_C_W = 5,
  parameter int MAX_DIV  = 4,
  parameter int SYNC_LEN = 12
) (
  input  logic                osc_clk_i,
  input  logic                ref_clk_i,
  input  logic                rst_ni,
  input  logic                pll_en_i,
  input  logic [3:0]          mode_i,
  input  logic [2:0]          oe_ni,
  input  logic                lock_det_i,
  output logic                fb_o,
  output logic [BANK_A_W-1:0] bank_a_o,
  output logic [BANK_B_W-1:0] bank_b_o,
  output logic [BANK_C_W-1:0] bank_c_o,
  output logic [2:0]          drv_en_o,
  output logic                lock_o
);

  localparam int NUM_DIV = 4;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic               src_clk;
  logic               run, load;
  logic [3:0]         mode_q;
  ratio_set_t         ratio_nxt;
  ratio_t             div_ratio [NUM_DIV];
  logic [NUM_DIV-1:0] lead, div_out;

  assign src_clk = pll_en_i ? osc_clk_i : ref_clk_i;

  clkdiv_ctrl #(.SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk_i      (src_clk),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .run_o      (run),
    .load_o     (load),
    .mode_q_o   (mode_q),
    .ratio_nxt_o(ratio_nxt)
  );

  assign div_ratio[0] = ratio_nxt.fb;
  assign div_ratio[1] = ratio_nxt.a;
  assign div_ratio[2] = ratio_nxt.b;
  assign div_ratio[3] = ratio_nxt.c;

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    clkdiv_divider #(.CNT_W(CNT_W)) u_div (
      .clk_i  (src_clk),
      .rst_ni (rst_ni),
      .run_i  (run),
      .load_i (load),
      .ratio_i(div_ratio[k]),
      .lead_o (lead[k]),
      .div_o  (div_out[k])
    );
  end

  clkdiv_lock_sync #(.STAGES(2)) u_lock (
    .clk_i (src_clk),
    .rst_ni(rst_ni),
    .det_i (lock_det_i),
    .qual_i(pll_en_i),
    .lock_o(lock_o)
  );

  assign fb_o     = div_out[0];
  assign bank_a_o = oe_ni[0] ? '0 : {BANK_A_W{div_out[1]}};
  assign bank_b_o = oe_ni[1] ? '0 : {BANK_B_W{div_out[2]}};
  assign bank_c_o = oe_ni[2] ? '0 : {BANK_C_W{div_out[3]}};
  assign drv_en_o = ~oe_ni;

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk
  import clkdiv_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pll_en_i,
  input logic       lock_det_i,
  input logic       lock_o,
  input logic       load_i,
  input logic [3:0] mode_q_i,
  input logic [3:0] lead_i
);

  ratio_set_t rs;
  logic [3:0] lead_exp;

  always_comb begin
    rs       = decode_mode(mode_q_i);
    lead_exp = {rs.c >= 3'd2, rs.b >= 3'd2, rs.a >= 3'd2, rs.fb >= 3'd2};
  end

  AST_LOCK_BYPASS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_i |-> !lock_o); // R11

  AST_LOCK_NEEDS_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> $past(lock_det_i, 2)); // R11

  AST_MODE_ONLY_AT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q_i) |-> $past(load_i)); // R7

  AST_LEAD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (lead_i == lead_exp)); // R6

endmodule

bind clkdiv_banks clkdiv_banks_chk u_chk (
  .clk_i     (src_clk),
  .rst_ni    (rst_ni),
  .pll_en_i  (pll_en_i),
  .lock_det_i(lock_det_i),
  .lock_o    (lock_o),
  .load_i    (load),
  .mode_q_i  (mode_q),
  .lead_i    (lead)
);

// File: tb/clkdiv_banks_tb.sv
`timescale 1ns/1ps
module clkdiv_banks_tb_top;

  localparam int SYNC = 12;

  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_ni  = 1'b0;
  logic       pll_en  = 1'b1;
  logic [3:0] mode_v  = 4'd4;
  logic [2:0] oe_v    = 3'b000;
  logic       det_v   = 1'b0;

  logic       fb_o, lock_o;
  logic [3:0] bank_a_o;
  logic [7:0] bank_b_o;
  logic [4:0] bank_c_o;
  logic [2:0] drv_en_o;

  int checks = 0;
  int errors = 0;
  int e = -1;
  int eff = 0;
  logic l1 = 1'b0, l2 = 1'b0;
  string ptag = "";

  int fb_tab [16] = '{1,1,1,1,1,3,3,3,2,2,2,2,2,4,4,4};
  int b_tab  [16] = '{1,1,1,2,3,1,3,1,1,2,2,2,4,2,2,2};
  int c_tab  [16] = '{1,2,1,2,1,3,1,1,1,1,2,4,2,1,2,4};

  always #2.5 osc_clk = ~osc_clk;
  always #7.5 ref_clk = ~ref_clk;

  wire src_b = pll_en ? osc_clk : ref_clk;

  clkdiv_banks dut_i (
    .osc_clk_i (osc_clk),
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_ni),
    .pll_en_i  (pll_en),
    .mode_i    (mode_v),
    .oe_ni     (oe_v),
    .lock_det_i(det_v),
    .fb_o      (fb_o),
    .bank_a_o  (bank_a_o),
    .bank_b_o  (bank_b_o),
    .bank_c_o  (bank_c_o),
    .drv_en_o  (drv_en_o),
    .lock_o    (lock_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s e=%0d act=%h exp=%h", ptag, req, e, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int n, input int hb);
    int h = 2 * (e % SYNC) + hb;
    return (h % (2 * n)) < n;
  endfunction

  task automatic sample(input int hb);
    logic fx = exp_bit(fb_tab[eff], hb);
    logic ax = exp_bit(1, hb);
    logic bx = exp_bit(b_tab[eff], hb);
    logic cx = exp_bit(c_tab[eff], hb);
    check("R1/R5/R6 fb", {7'd0, fb_o}, {7'd0, fx});
    check("R2/R8 bank A", {4'd0, bank_a_o}, oe_v[0] ? 8'd0 : {4'd0, {4{ax}}});
    check("R3/R5/R8 bank B", bank_b_o, oe_v[1] ? 8'd0 : {8{bx}});
    check("R4/R5/R8 bank C", {3'd0, bank_c_o}, oe_v[2] ? 8'd0 : {3'd0, {5{cx}}});
    check("R8 drive enable", {5'd0, drv_en_o}, {5'd0, ~oe_v});
    check("R11 lock", {7'd0, lock_o}, {7'd0, pll_en & l2});
  endtask

  task automatic reset_state();
    for (int i = 0; i < 4; i++) begin
      @(posedge src_b); #1;
      check("R10 reset outputs", {fb_o, bank_c_o[0], bank_b_o[0], bank_a_o[0], lock_o, 3'd0},
            8'd0);
      check("R10 reset banks", {3'd0, bank_c_o} | bank_b_o | {4'd0, bank_a_o}, 8'd0);
    end
  endtask

  task automatic release_reset();
    @(negedge src_b); #1;
    rst_ni = 1'b1;
    e = -1; l1 = 1'b0; l2 = 1'b0;
  endtask

  // rnd: 0 directed, 1 random mode/enable/lock
  task automatic run_cycles(input int n, input int rnd);
    for (int i = 0; i < n; i++) begin
      @(posedge src_b); #1;
      e++;
      if (e % SYNC == 0) eff = int'(mode_v); // R7 mode applied only here
      l2 = l1;
      l1 = det_v;
      sample(0);
      @(negedge src_b); #1;
      sample(1);
      if (rnd != 0) begin
        if ($urandom % 10 == 0) mode_v = 4'($urandom % 16);
        if ($urandom % 7 == 0)  oe_v   = 3'($urandom % 8);
        det_v = ($urandom % 4) != 0;
      end
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ptag = "R10";
    reset_state();
    release_reset();
    ptag = "";
    // directed sweep: mode changed at an off-boundary point each time
    for (int m = 0; m < 16; m++) begin
      run_cycles(5, 0);
      mode_v = 4'(m);
      oe_v   = 3'(m);
      det_v  = m[0];
      run_cycles(31, 0);
    end
    // odd <-> even switches at the boundary
    oe_v = 3'b000;
    mode_v = 4'd12; run_cycles(24, 0);
    mode_v = 4'd6;  run_cycles(24, 0);
    mode_v = 4'd11; run_cycles(24, 0);
    run_cycles(800, 1);
    // bypass: reference clock as source
    rst_ni = 1'b0;
    pll_en = 1'b0;
    ptag = "R9 R10";
    reset_state();
    mode_v = 4'd5; oe_v = 3'b000; det_v = 1'b1;
    release_reset();
    ptag = "R9";
    run_cycles(36, 0);
    run_cycles(120, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule